// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host side of a serial link to a multi-channel successive-approximation converter. A client hands it a 4-bit channel number on a valid/ready request port. The block then runs one transfer frame. It pulls chip select low and waits a setup interval. It then toggles an I/O clock for a fixed number of periods, 10 to 16, set by a parameter. While the clock runs, it shifts the channel address out MSB first and shifts in the 10-bit result of the conversion started by the previous frame.

The converter begins converting after the tenth clock and signals completion on its end-of-conversion line. The block waits for that line to fall and then rise again before it accepts the next request. If the line does not come back within a bounded number of cycles, the block reports a timeout and returns to idle.

Each frame returns the result of the previous conversion, so the block keeps the channel of each request and attaches it to the result read one frame later. The first result after reset carries no valid channel and is marked as such. A parameter chooses whether chip select is released between frames or held low from the first frame on.

Top module: `adc_serial_host`

## Requirements
- R1: `req_ready` is high only while no frame is in progress; a request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low from the following cycle until the frame ends.
- R2: Each frame produces exactly FRAME_CLKS rising edges on `io_clk`; each high phase lasts DIV_HALF system clock cycles, and `io_clk` rests low outside a frame.
- R3: When a frame starts with chip select high, `cs_n` falls and at least SETUP_CYCLES system clock cycles pass before the first rising edge of `io_clk`; `cs_n` is low for the whole clocking part of every frame.
- R4: The requested channel appears on `addr_out` MSB first, one bit per I/O clock period, and is stable across each of the first four rising edges of `io_clk`.
- R5: `res_data` holds the bits seen on `sdata_in` at rising edges 1 to 10 of `io_clk`, the first of them in bit 9; bits seen at later rising edges are discarded.
- R6: `res_chan` is the channel requested in the previous frame; `res_tag_ok` is 0 for the first result after reset and 1 for every later one.
- R7: After the last I/O clock of a frame, `res_valid` pulses for one cycle; `req_ready` rises again only after `eoc_in` has gone low and then high.
- R8: If `eoc_in` has not completed its low-then-high return within EOC_TIMEOUT cycles after the last I/O clock, `timeout_err` pulses for one cycle and the block returns to idle.
- R9: With HOLD_CS_LOW = 0, `cs_n` is high whenever the block is idle; with HOLD_CS_LOW = 1, `cs_n` stays low after the first frame has started.
- R10: During and right after reset, `cs_n` is high, `io_clk` is low, `req_ready` is high, and `res_valid` and `timeout_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | ADDR_W | Channel to convert next |
| req_ready | output | 1 | Block idle, request can be taken |
| cs_n | output | 1 | Chip select to converter, active low |
| io_clk | output | 1 | Serial I/O clock to converter |
| addr_out | output | 1 | Serial channel address, MSB first |
| sdata_in | input | 1 | Serial result bits from converter |
| eoc_in | input | 1 | End-of-conversion flag from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Result read in the frame just finished |
| res_chan | output | ADDR_W | Channel that result belongs to |
| res_tag_ok | output | 1 | res_chan is meaningful (0 on first frame) |
| timeout_err | output | 1 | One-cycle pulse: end of conversion never returned |

## Verification
Some properties are watched on every cycle. The address stays steady across its sampling edges, and the rising-edge count never exceeds the frame length. Chip select is low while clocking and high when idle in the toggling variant. The I/O clock rests low outside transfers, the timeout counter stays below its limit, and the error flag lasts one cycle. Whether the right bits land in the result and carry the right channel tag can only be shown by the bench: a converter model returns a channel-dependent word, and the bench compares each result with the word for the channel sent one frame earlier. That model also provides the setup spacing, the end-of-conversion wait, a stuck conversion for the timeout, and the continuous chip-select variant.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_XFER,
    S_WAIT_LO,
    S_WAIT_HI
  } host_state_t;
endpackage

// File: rtl/adc_ioclk_gen.sv
// I/O clock divider: equal high/low phases of DIV_HALF system cycles.
// Strobes mark the system clock edge at which io_clk changes.
module adc_ioclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic io_clk,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] ph_cnt;
  logic          clk_q;
  logic          edge_now;

  assign edge_now = run && (ph_cnt == CW'(DIV_HALF - 1));
  assign rise_now = edge_now && !clk_q;
  assign fall_now = edge_now && clk_q;
  assign io_clk   = clk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph_cnt <= '0;
      clk_q  <= 1'b0;
    end else if (edge_now) begin
      ph_cnt <= '0;
      clk_q  <= ~clk_q;
    end else begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end

  // R2: a stopped divider leaves the I/O clock low
  p_stop_low_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !io_clk);
endmodule

// File: rtl/adc_frame_shifter.sv
// Address serializer and result deserializer for one frame.
module adc_frame_shifter #(
  parameter int FRAME_CLKS = 12,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] chan,
  input  logic              rise_now,
  input  logic              fall_now,
  input  logic              sdata_in,
  output logic              addr_out,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  localparam int MAXC = (FRAME_CLKS > DATA_W) ? FRAME_CLKS : DATA_W;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0]     rise_cnt;
  logic [CW-1:0]     fall_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      addr_sh  <= '0;
      data_sh  <= '0;
    end else if (load) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      addr_sh  <= chan;
      data_sh  <= '0;
    end else begin
      if (rise_now) begin
        rise_cnt <= rise_cnt + 1'b1;
        if (rise_cnt < CW'(DATA_W))
          data_sh <= {data_sh[DATA_W-2:0], sdata_in};
      end
      if (fall_now) begin
        fall_cnt <= fall_cnt + 1'b1;
        addr_sh  <= {addr_sh[ADDR_W-2:0], 1'b0};
      end
    end
  end

  assign addr_out = addr_sh[ADDR_W-1];
  assign data     = data_sh;
  assign done     = fall_now && (fall_cnt == CW'(FRAME_CLKS - 1));

  // R2: never more rising edges than the frame length
  p_rise_bound_r2: assert property (@(posedge clk) disable iff (rst)
    rise_now |-> rise_cnt < CW'(FRAME_CLKS));
  // R4: address bit steady across its sampling edge
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_now && rise_cnt < CW'(ADDR_W)) |-> $stable(addr_out));
endmodule

// File: rtl/adc_tag_pipe.sv
// Holds the channel of the frame in flight and of the one before it.
module adc_tag_pipe #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] chan,
  input  logic              advance,
  output logic [ADDR_W-1:0] prev_chan,
  output logic              prev_ok
);
  logic [ADDR_W-1:0] cur_chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_chan  <= '0;
      prev_chan <= '0;
      prev_ok   <= 1'b0;
    end else begin
      if (load)
        cur_chan <= chan;
      if (advance) begin
        prev_chan <= cur_chan;
        prev_ok   <= 1'b1;
      end
    end
  end

  // R6: once a tag is valid it stays valid until reset
  p_tag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    prev_ok |=> prev_ok);
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int DIV_HALF     = 2,
  parameter int FRAME_CLKS   = 12,
  parameter int SETUP_CYCLES = 3,
  parameter int EOC_TIMEOUT  = 200,
  parameter int HOLD_CS_LOW  = 0,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_chan,
  output logic              req_ready,
  output logic              cs_n,
  output logic              io_clk,
  output logic              addr_out,
  input  logic              sdata_in,
  input  logic              eoc_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [ADDR_W-1:0] res_chan,
  output logic              res_tag_ok,
  output logic              timeout_err
);
  localparam int SCW = $clog2(SETUP_CYCLES + 1);
  localparam int TCW = $clog2(EOC_TIMEOUT + 1);

  host_state_t       state;
  logic [SCW-1:0]    setup_cnt;
  logic [TCW-1:0]    tmo_cnt;
  logic              cs_q;
  logic              eoc_s1, eoc_s2;
  logic              accept;
  logic              run;
  logic              rise_now, fall_now;
  logic              frame_done;
  logic [DATA_W-1:0] shift_data;
  logic [ADDR_W-1:0] prev_chan;
  logic              prev_ok;
  logic              tmo_hit;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign run       = (state == S_XFER);
  assign cs_n      = cs_q;
  assign tmo_hit   = (tmo_cnt == TCW'(EOC_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_s1 <= 1'b1;
      eoc_s2 <= 1'b1;
    end else begin
      eoc_s1 <= eoc_in;
      eoc_s2 <= eoc_s1;
    end
  end

  adc_ioclk_gen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .io_clk   (io_clk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  adc_frame_shifter #(
    .FRAME_CLKS (FRAME_CLKS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .chan     (req_chan),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .sdata_in (sdata_in),
    .addr_out (addr_out),
    .data     (shift_data),
    .done     (frame_done)
  );

  adc_tag_pipe #(.ADDR_W(ADDR_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .chan      (req_chan),
    .advance   (frame_done),
    .prev_chan (prev_chan),
    .prev_ok   (prev_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cs_q        <= 1'b1;
      setup_cnt   <= '0;
      tmo_cnt     <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_chan    <= '0;
      res_tag_ok  <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      res_valid   <= 1'b0;
      timeout_err <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            cs_q      <= 1'b0;
            setup_cnt <= '0;
            state     <= cs_q ? S_SETUP : S_XFER;
          end
        end
        S_SETUP: begin
          if (setup_cnt == SCW'(SETUP_CYCLES - 1))
            state <= S_XFER;
          else
            setup_cnt <= setup_cnt + 1'b1;
        end
        S_XFER: begin
          if (frame_done) begin
            res_valid  <= 1'b1;
            res_data   <= shift_data;
            res_chan   <= prev_chan;
            res_tag_ok <= prev_ok;
            tmo_cnt    <= '0;
            state      <= S_WAIT_LO;
          end
        end
        S_WAIT_LO: begin
          if (tmo_hit) begin
            timeout_err <= 1'b1;
            cs_q        <= (HOLD_CS_LOW == 0);
            state       <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
            if (!eoc_s2)
              state <= S_WAIT_HI;
          end
        end
        S_WAIT_HI: begin
          if (tmo_hit) begin
            timeout_err <= 1'b1;
            cs_q        <= (HOLD_CS_LOW == 0);
            state       <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
            if (eoc_s2) begin
              cs_q  <= (HOLD_CS_LOW == 0);
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: chip select held low while the I/O clock runs
  p_cs_low_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_XFER) |-> !cs_n);
  // R2: I/O clock rests low outside the clocking phase
  p_ioclk_rest_r2: assert property (@(posedge clk) disable iff (rst)
    (state != S_XFER) |-> !io_clk);
  // R7: a result strobe is never seen while a new request could be taken
  p_busy_on_result_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !req_ready);
  // R8: timeout counter stays within its window
  p_tmo_bound_r8: assert property (@(posedge clk) disable iff (rst)
    tmo_cnt < TCW'(EOC_TIMEOUT));
  // R8: error report is a single-cycle pulse
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);

  generate
    if (HOLD_CS_LOW == 0) begin : g_toggle_cs
      // R9: chip select released whenever idle
      p_cs_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> cs_n);
    end else begin : g_hold_cs
      // R9: once low, chip select stays low
      p_cs_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> !cs_n);
    end
  endgenerate
endmodule

// File: tb/adc_serial_host_bench.sv
// Behavioural converter: returns the word of the channel addressed one frame earlier.
module adc_dev_model #(
  parameter int CONV_T = 600
) (
  input  logic cs_n,
  input  logic io_clk,
  input  logic addr,
  input  logic stuck,
  output logic sdata,
  output logic eoc
);
  logic [9:0] result, outreg;
  logic [3:0] areg;
  int rcnt, fcnt;

  function automatic logic [9:0] conv_of(input logic [3:0] c);
    return 10'h2A5 ^ (10'(c) * 10'd37);
  endfunction

  task automatic start_frame();
    rcnt   = 0;
    fcnt   = 0;
    outreg = result;
    sdata  = result[9];
  endtask

  initial begin
    result = 10'h155;
    outreg = '0;
    areg   = '0;
    rcnt   = 0;
    fcnt   = 0;
    sdata  = 1'b0;
    eoc    = 1'b1;
  end

  always @(negedge cs_n) start_frame();

  always @(posedge io_clk) begin
    if (!cs_n) begin
      if (rcnt < 4) areg = {areg[2:0], addr};
      rcnt++;
    end
  end

  always @(negedge io_clk) begin
    if (!cs_n) begin
      outreg = {outreg[8:0], 1'b0};
      sdata  = outreg[9];
      fcnt++;
      if (fcnt == 10) begin
        eoc = 1'b0;
        fork
          begin
            #(CONV_T);
            wait (!stuck);
            result = conv_of(areg);
            eoc = 1'b1;
            if (!cs_n) start_frame();
          end
        join_none
      end
    end
  end
endmodule

module adc_serial_host_bench;
  localparam int CLK_P   = 10;
  localparam int DIV     = 2;
  localparam int SETUP_P = 3;
  localparam int FR_A    = 12;
  localparam int FR_B    = 16;
  localparam int NVEC    = 8;
  localparam logic [3:0] CHANS [NVEC] = '{4'd3, 4'd10, 4'd0, 4'd15, 4'd7, 4'd7, 4'd1, 4'd12};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_v = 1'b0;
  logic [3:0] req_ch = '0;
  logic sel = 1'b0;
  logic stuck_a = 1'b0;

  logic rdy_a, cs_a, io_a, ad_a, sd_a, eoc_a, rv_a, ok_a, tmo_a;
  logic rdy_b, cs_b, io_b, ad_b, sd_b, eoc_b, rv_b, ok_b, tmo_b;
  logic [9:0] rd_a, rd_b;
  logic [3:0] rc_a, rc_b;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_serial_host #(.DIV_HALF(DIV), .FRAME_CLKS(FR_A), .SETUP_CYCLES(SETUP_P),
                    .EOC_TIMEOUT(200), .HOLD_CS_LOW(0)) u_adc_serial_host (
    .clk(clk), .rst(rst), .req_valid(req_v && !sel), .req_chan(req_ch), .req_ready(rdy_a),
    .cs_n(cs_a), .io_clk(io_a), .addr_out(ad_a), .sdata_in(sd_a), .eoc_in(eoc_a),
    .res_valid(rv_a), .res_data(rd_a), .res_chan(rc_a), .res_tag_ok(ok_a), .timeout_err(tmo_a));

  adc_serial_host #(.DIV_HALF(DIV), .FRAME_CLKS(FR_B), .SETUP_CYCLES(SETUP_P),
                    .EOC_TIMEOUT(200), .HOLD_CS_LOW(1)) u_adc_serial_host_cont (
    .clk(clk), .rst(rst), .req_valid(req_v && sel), .req_chan(req_ch), .req_ready(rdy_b),
    .cs_n(cs_b), .io_clk(io_b), .addr_out(ad_b), .sdata_in(sd_b), .eoc_in(eoc_b),
    .res_valid(rv_b), .res_data(rd_b), .res_chan(rc_b), .res_tag_ok(ok_b), .timeout_err(tmo_b));

  adc_dev_model #(.CONV_T(60*CLK_P)) u_dev_a (.cs_n(cs_a), .io_clk(io_a), .addr(ad_a),
    .stuck(stuck_a), .sdata(sd_a), .eoc(eoc_a));
  adc_dev_model #(.CONV_T(60*CLK_P)) u_dev_b (.cs_n(cs_b), .io_clk(io_b), .addr(ad_b),
    .stuck(1'b0), .sdata(sd_b), .eoc(eoc_b));

  wire       rdy_m = sel ? rdy_b : rdy_a;
  wire       cs_m  = sel ? cs_b  : cs_a;
  wire       io_m  = sel ? io_b  : io_a;
  wire       eoc_m = sel ? eoc_b : eoc_a;
  wire       rv_m  = sel ? rv_b  : rv_a;
  wire       ok_m  = sel ? ok_b  : ok_a;
  wire       tmo_m = sel ? tmo_b : tmo_a;
  wire [9:0] rd_m  = sel ? rd_b  : rd_a;
  wire [3:0] rc_m  = sel ? rc_b  : rc_a;

  function automatic logic [9:0] expect_word(input logic [3:0] c);
    return 10'h2A5 ^ (10'(c) * 10'd37);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Port monitor, sampled on the falling system clock edge
  int rises = 0, gap = -1, gcnt = 0, hl = 0;
  bit counting = 0, hi_bad = 0, prev_cs = 1, prev_io = 0, prev_rdy = 1;
  always @(negedge clk) begin
    if (prev_rdy && !rdy_m) begin
      rises = 0; gap = -1; hi_bad = 0; counting = 0; hl = 0;
    end
    if (prev_cs && !cs_m) begin counting = 1; gcnt = 0; end
    if (counting) gcnt++;
    if (io_m && !prev_io) begin
      rises++;
      if (counting) begin gap = gcnt; counting = 0; end
    end
    if (io_m) hl++;
    else begin
      if (prev_io && hl != DIV) hi_bad = 1;
      hl = 0;
    end
    prev_cs = cs_m; prev_io = io_m; prev_rdy = rdy_m;
  end

  task automatic run_frame(input logic [3:0] ch, input logic [9:0] exp_d, input logic [3:0] exp_c,
                           input logic exp_ok, input bit exp_setup, input bit exp_tmo, input int frame_len);
    bit saw_tmo = 0;
    while (!rdy_m) @(negedge clk);
    req_ch = ch; req_v = 1'b1;
    @(negedge clk);
    req_v = 1'b0;
    chk("R1 ready drops after accept", int'(rdy_m), 0);
    while (!rv_m) @(negedge clk);
    chk("R5 result word", int'(rd_m), int'(exp_d));
    chk("R6 result channel tag", int'(rc_m), int'(exp_c));
    chk("R6 tag valid flag", int'(ok_m), int'(exp_ok));
    chk("R2 io clock rising edges per frame", rises, frame_len);
    chk("R2 io clock high phase length", int'(hi_bad), 0);
    chk("R7 busy at result strobe", int'(rdy_m), 0);
    if (exp_setup) chk("R3 setup before first io clock", int'(gap >= SETUP_P + 1), 1);
    @(negedge clk);
    chk("R7 result strobe is one cycle", int'(rv_m), 0);
    while (!rdy_m) begin
      if (tmo_m) saw_tmo = 1;
      @(negedge clk);
    end
    if (tmo_m) saw_tmo = 1;
    chk("R8 timeout report", int'(saw_tmo), int'(exp_tmo));
    if (!exp_tmo) chk("R7 ready only after end of conversion returns", int'(eoc_m), 1);
    chk("R9 chip select level when idle", int'(cs_m), sel ? 0 : 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 cs_n in reset", int'(cs_a), 1);
    chk("R10 io_clk in reset", int'(io_a), 0);
    chk("R10 req_ready in reset", int'(rdy_a), 1);
    chk("R10 res_valid in reset", int'(rv_a), 0);
    chk("R10 timeout_err in reset", int'(tmo_a), 0);
    chk("R10 cs_n in reset, held variant", int'(cs_b), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle after reset release", int'(rdy_a && cs_a && !io_a), 1);

    // Vector table walk on the toggling chip-select instance
    for (int i = 0; i < NVEC; i++) begin
      if (i == 0) run_frame(CHANS[i], 10'h155, 4'd0, 1'b0, 1, 0, FR_A);
      else        run_frame(CHANS[i], expect_word(CHANS[i-1]), CHANS[i-1], 1'b1, 1, 0, FR_A);
    end

    // R8: conversion never completes
    stuck_a = 1'b1;
    run_frame(4'd11, expect_word(CHANS[NVEC-1]), CHANS[NVEC-1], 1'b1, 1, 1, FR_A);
    chk("R8 end of conversion still low at timeout", int'(eoc_a), 0);
    stuck_a = 1'b0;
    while (!eoc_a) @(negedge clk);
    run_frame(4'd2, expect_word(4'd11), 4'd11, 1'b1, 1, 0, FR_A);

    // Held chip-select instance with 16-clock frames
    sel = 1'b1;
    @(negedge clk);
    run_frame(4'd5, 10'h155, 4'd0, 1'b0, 1, 0, FR_B);
    run_frame(4'd9, expect_word(4'd5), 4'd5, 1'b1, 0, 0, FR_B);
    run_frame(4'd14, expect_word(4'd9), 4'd9, 1'b1, 0, 0, FR_B);
    run_frame(4'd0, expect_word(4'd14), 4'd14, 1'b1, 0, 0, FR_B);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule